// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block is the acceptance and dispatch core of a per-processor interrupt controller. Requests arrive one per cycle, each with an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary vectored requests are collected in a 256-entry request set. Three unmaskable kinds (system-management, non-maskable and initialisation) and one externally vectored kind are held as single pending slots. Each slot keeps the vector it arrived with.

Every cycle the block tells the core whether an interrupt should be taken. It uses the core's interrupt-enable flag and a task-priority value for this. It also presents the kind and vector that would win. When the core acknowledges, the winner is retired from its pending state. A regular vector is moved into a 256-entry in-service set at that point. An end-of-interrupt strobe retires the highest in-service vector, which opens the way for lower-priority regular vectors.

Top module: `vip_arbiter`

## Requirements
- R1: The delivery mode codes are 0 fixed, 1 lowest-priority, 2 system-management, 4 non-maskable, 5 initialisation and 7 external. A request with code 0 or 1 sets the request bit of its vector. The highest set request vector is the regular candidate.
- R2: The trigger bit of a vector is written only when its request bit goes from clear to set: level gives 1 and edge gives 0. A repeated request for a vector that is already requested leaves the trigger bit unchanged. On a regular candidate, `dsp_level` shows the trigger bit of that candidate.
- R3: A system-management, non-maskable or initialisation request sets its own pending slot and latches its vector, but only if that slot is clear. A request to a slot that is already set changes neither the slot nor its vector.
- R4: An external request (code 7) sets the external slot and latches its vector under the same only-if-clear rule. Codes 3 and 6 are ignored.
- R5: `take_irq` is 1 whenever any unmaskable slot is pending, whatever `int_en` is. With no unmaskable slot pending, `take_irq` is 0 whenever `int_en` is 0.
- R6: With `int_en` at 1 and no special slot pending, a regular candidate is reported only if both of these hold: it is numerically above the highest in-service vector, and its upper nibble is above the upper nibble of `task_prio`. An empty set counts as vector 0.
- R7: `dsp_kind` encodes the winner as 0 none, 1 system-management, 2 non-maskable, 3 initialisation, 4 external, 5 regular. The priority order is system-management, then non-maskable, then initialisation, then external, then regular. An acknowledge clears only the winning slot.
- R8: Acknowledging a regular winner clears its request bit and sets its in-service bit. The next-highest request then becomes the candidate.
- R9: `eoi` clears the highest set in-service bit.
- R10: After reset all sets and slots are clear, `take_irq` is 0 and `dsp_kind` is 0.
- R11: An `ack` while `take_irq` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming request strobe |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode code |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| int_en | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task priority; upper nibble is the class used for gating |
| ack | input | 1 | Core accepts the presented interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| take_irq | output | 1 | An interrupt should be taken |
| dsp_kind | output | 3 | Kind of the winning interrupt |
| dsp_vector | output | 8 | Vector of the winning interrupt |
| dsp_level | output | 1 | Trigger bit of a regular winner |

## Verification
A corrupted request, in-service or trigger bit shows at the ports only when its vector becomes the highest candidate. Until then it stays hidden behind higher vectors. The tests therefore walk the candidate down through several vectors, using acknowledges and end-of-interrupt strobes, so that each bit is exposed one cycle after the edge that changed it. A wrong slot flag or latched vector shows at once in `dsp_kind` and `dsp_vector`, because the unmaskable kinds win whatever `int_en` is. A summary flag that fails to clear would keep `take_irq` high after the last unmaskable slot has been acknowledged.

// File: rtl/vip_pkg.sv
package vip_pkg;
    localparam int VEC_W   = 8;
    localparam int NVEC    = 1 << VEC_W;
    localparam int CLASS_W = 4;
    localparam int MODE_W  = 3;
    localparam int KIND_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMGMT  = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMASK  = 3'd4,
        DM_START  = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXTV   = 3'd7
    } dmode_e;

    typedef enum logic [KIND_W-1:0] {
        WK_NONE  = 3'd0,
        WK_SMGMT = 3'd1,
        WK_NMASK = 3'd2,
        WK_START = 3'd3,
        WK_EXTV  = 3'd4,
        WK_REG   = 3'd5
    } wkind_e;

    typedef struct packed {
        logic             pend;
        logic [VEC_W-1:0] vec;
    } slot_t;

    typedef struct packed {
        slot_t smgmt;
        slot_t nmask;
        slot_t start;
        slot_t extv;
        logic  unm;
    } special_t;

    function automatic logic is_regular(input logic [MODE_W-1:0] m);
        return (m == DM_FIXED) || (m == DM_LOWEST);
    endfunction

    function automatic logic [CLASS_W-1:0] class_of(input logic [VEC_W-1:0] v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction
endpackage

// File: rtl/vip_prio_enc.sv
module vip_prio_enc #(
    parameter  int WIDTH = 256,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic [IDX_W-1:0] top_idx,
    output logic             any
);
    always_comb begin
        top_idx = '0;
        any     = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_in[i]) begin
                top_idx = IDX_W'(i);
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vip_vec_bank.sv
module vip_vec_bank
    import vip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             take_top,
    input  logic             eoi,
    output logic [VEC_W-1:0] req_top,
    output logic [VEC_W-1:0] svc_top,
    output logic             top_level
);
    logic [NVEC-1:0] req_bits;
    logic [NVEC-1:0] svc_bits;
    logic [NVEC-1:0] trg_bits;
    logic            req_any;
    logic            svc_any;

    vip_prio_enc #(.WIDTH(NVEC)) u_req_enc (
        .bits_in (req_bits),
        .top_idx (req_top),
        .any     (req_any)
    );

    vip_prio_enc #(.WIDTH(NVEC)) u_svc_enc (
        .bits_in (svc_bits),
        .top_idx (svc_top),
        .any     (svc_any)
    );

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(g);
        logic hit_set;
        logic hit_take;
        logic hit_eoi;
        assign hit_set  = set_valid && (set_vec == MY_VEC);
        assign hit_take = take_top && req_any && (req_top == MY_VEC);
        assign hit_eoi  = eoi && svc_any && (svc_top == MY_VEC);

        always_ff @(posedge clk) begin
            if (rst) begin
                req_bits[g] <= 1'b0;
                svc_bits[g] <= 1'b0;
                trg_bits[g] <= 1'b0;
            end else begin
                if (hit_take) begin
                    req_bits[g] <= 1'b0;
                end else if (hit_set) begin
                    req_bits[g] <= 1'b1;
                end
                if (hit_set && !req_bits[g]) begin
                    trg_bits[g] <= set_level;
                end
                if (hit_take) begin
                    svc_bits[g] <= 1'b1;
                end else if (hit_eoi) begin
                    svc_bits[g] <= 1'b0;
                end
            end
        end
    end

    assign top_level = trg_bits[req_top];

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && svc_any && !take_top) |=> ($countones(svc_bits) == $past($countones(svc_bits)) - 1)); // R9

    AST_TAKE_MOVES_TO_SVC: assert property (@(posedge clk) disable iff (rst)
        (take_top && req_any && !set_valid && !eoi) |=>
            ($countones(req_bits) == $past($countones(req_bits)) - 1) &&
            ($countones(svc_bits) == $past($countones(svc_bits)) + 1)); // R8

    AST_REPEAT_KEEPS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (set_valid && req_bits[set_vec] && !take_top) |=> $stable(trg_bits)); // R2
endmodule

// File: rtl/vip_special_slots.sv
module vip_special_slots
    import vip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              clr_smgmt,
    input  logic              clr_nmask,
    input  logic              clr_start,
    input  logic              clr_extv,
    output special_t          state
);
    special_t st_q;
    special_t st_n;
    logic     any_unm_accept;

    always_comb begin
        st_n           = st_q;
        any_unm_accept = 1'b0;

        if (clr_smgmt) st_n.smgmt.pend = 1'b0;
        if (clr_nmask) st_n.nmask.pend = 1'b0;
        if (clr_start) st_n.start.pend = 1'b0;
        if (clr_extv)  st_n.extv.pend  = 1'b0;

        if (req_valid) begin
            unique case (dmode_e'(req_mode))
                DM_SMGMT: if (!st_q.smgmt.pend) begin
                    st_n.smgmt     = '{pend: 1'b1, vec: req_vector};
                    any_unm_accept = 1'b1;
                end
                DM_NMASK: if (!st_q.nmask.pend) begin
                    st_n.nmask     = '{pend: 1'b1, vec: req_vector};
                    any_unm_accept = 1'b1;
                end
                DM_START: if (!st_q.start.pend) begin
                    st_n.start     = '{pend: 1'b1, vec: req_vector};
                    any_unm_accept = 1'b1;
                end
                DM_EXTV: if (!st_q.extv.pend) begin
                    st_n.extv = '{pend: 1'b1, vec: req_vector};
                end
                default: ;
            endcase
        end

        if (any_unm_accept) begin
            st_n.unm = 1'b1;
        end else if ((clr_smgmt || clr_nmask || clr_start) &&
                     !(st_n.smgmt.pend || st_n.nmask.pend || st_n.start.pend)) begin
            st_n.unm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    assign state = st_q;

    AST_UNM_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (rst)
        st_q.unm == (st_q.smgmt.pend || st_q.nmask.pend || st_q.start.pend)); // R3

    AST_HELD_SLOT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (st_q.nmask.pend && !clr_nmask) |=> $stable(st_q.nmask.vec)); // R3

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_mode == DM_RSV3 || req_mode == DM_RSV6) &&
         !clr_smgmt && !clr_nmask && !clr_start && !clr_extv) |=> $stable(st_q)); // R4
endmodule

// File: rtl/vip_arbiter.sv
module vip_arbiter
    import vip_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VEC_W-1:0]     req_vector,
    input  logic [MODE_W-1:0]    req_mode,
    input  logic                 req_level,
    input  logic                 int_en,
    input  logic [VEC_W-1:0]     task_prio,
    input  logic                 ack,
    input  logic                 eoi,
    output logic                 take_irq,
    output logic [KIND_W-1:0]    dsp_kind,
    output logic [VEC_W-1:0]     dsp_vector,
    output logic                 dsp_level
);
    special_t         spec;
    logic [VEC_W-1:0] req_top;
    logic [VEC_W-1:0] svc_top;
    logic             top_level;
    logic             class_ok;
    logic             ack_fire;
    wkind_e           kind;

    vip_special_slots u_slots (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_vector (req_vector),
        .clr_smgmt  (ack_fire && kind == WK_SMGMT),
        .clr_nmask  (ack_fire && kind == WK_NMASK),
        .clr_start  (ack_fire && kind == WK_START),
        .clr_extv   (ack_fire && kind == WK_EXTV),
        .state      (spec)
    );

    vip_vec_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_valid (req_valid && is_regular(req_mode)),
        .set_vec   (req_vector),
        .set_level (req_level),
        .take_top  (ack_fire && kind == WK_REG),
        .eoi       (eoi),
        .req_top   (req_top),
        .svc_top   (svc_top),
        .top_level (top_level)
    );

    assign class_ok = (req_top > svc_top) && (class_of(req_top) > class_of(task_prio));

    always_comb begin
        kind       = WK_NONE;
        dsp_vector = '0;
        if (spec.unm) begin
            if (spec.smgmt.pend) begin
                kind       = WK_SMGMT;
                dsp_vector = spec.smgmt.vec;
            end else if (spec.nmask.pend) begin
                kind       = WK_NMASK;
                dsp_vector = spec.nmask.vec;
            end else if (spec.start.pend) begin
                kind       = WK_START;
                dsp_vector = spec.start.vec;
            end
        end else if (int_en && spec.extv.pend) begin
            kind       = WK_EXTV;
            dsp_vector = spec.extv.vec;
        end else if (int_en && class_ok) begin
            kind       = WK_REG;
            dsp_vector = req_top;
        end
    end

    assign take_irq  = (kind != WK_NONE);
    assign ack_fire  = ack && take_irq;
    assign dsp_kind  = kind;
    assign dsp_level = (kind == WK_REG) ? top_level : 1'b0;

    AST_UNMASKABLE_TAKES: assert property (@(posedge clk) disable iff (rst)
        spec.unm |-> take_irq); // R5

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!int_en && !spec.unm) |-> !take_irq); // R5

    AST_SMGMT_FIRST: assert property (@(posedge clk) disable iff (rst)
        spec.smgmt.pend |-> (dsp_kind == WK_SMGMT)); // R7

    AST_REG_ABOVE_SVC: assert property (@(posedge clk) disable iff (rst)
        (dsp_kind == WK_REG) |-> (dsp_vector > svc_top)); // R6
endmodule

// File: tb/vip_arbiter_bench.sv
module vip_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [7:0] req_vector;
    logic [2:0] req_mode;
    logic       req_level;
    logic       int_en;
    logic [7:0] task_prio;
    logic       ack;
    logic       eoi;
    logic       take_irq;
    logic [2:0] dsp_kind;
    logic [7:0] dsp_vector;
    logic       dsp_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vip_arbiter u_vip_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .int_en(int_en),
        .task_prio(task_prio), .ack(ack), .eoi(eoi), .take_irq(take_irq),
        .dsp_kind(dsp_kind), .dsp_vector(dsp_vector), .dsp_level(dsp_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input int tk, input int kd, input int vc);
        chk({tag, " take"}, int'(take_irq), tk);
        chk({tag, " kind"}, int'(dsp_kind), kd);
        chk({tag, " vector"}, int'(dsp_vector), vc);
    endtask

    task automatic send(input int vec, input int mode, input bit lvl);
        @(negedge clk);
        req_valid = 1'b1; req_vector = 8'(vec); req_mode = 3'(mode); req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_out("R10 reset", 0, 0, 0);
        pulse_ack();
        expect_out("R11 idle ack", 0, 0, 0);
    endtask

    task automatic t_regular_nesting();
        int_en = 1'b1; task_prio = 8'h00;
        send(8'h35, 0, 1'b0);
        expect_out("R1 fixed", 1, 5, 8'h35);
        pulse_ack();
        expect_out("R8 after ack", 0, 0, 0);
        send(8'h32, 1, 1'b0);
        expect_out("R6 below svc", 0, 0, 0);
        send(8'h51, 0, 1'b0);
        expect_out("R6 above svc", 1, 5, 8'h51);
        pulse_ack();
        pulse_eoi();
        expect_out("R9 first eoi", 0, 0, 0);
        pulse_eoi();
        expect_out("R9 second eoi lowest", 1, 5, 8'h32);
        pulse_ack();
        pulse_eoi();
        expect_out("R9 drained", 0, 0, 0);
    endtask

    task automatic t_task_prio();
        task_prio = 8'h40;
        send(8'h45, 0, 1'b0);
        expect_out("R6 same class", 0, 0, 0);
        task_prio = 8'h3F;
        @(negedge clk);
        expect_out("R6 class above", 1, 5, 8'h45);
        int_en = 1'b0;
        @(negedge clk);
        chk("R5 masked", int'(take_irq), 0);
        int_en = 1'b1; task_prio = 8'h00;
        pulse_ack();
        pulse_eoi();
    endtask

    task automatic t_trigger();
        send(8'h70, 0, 1'b1);
        send(8'h70, 0, 1'b0);
        expect_out("R2 level", 1, 5, 8'h70);
        chk("R2 repeat keeps level", int'(dsp_level), 1);
        pulse_ack();
        pulse_eoi();
        send(8'h71, 1, 1'b0);
        chk("R2 edge", int'(dsp_level), 0);
        pulse_ack();
        pulse_eoi();
    endtask

    task automatic t_special();
        int_en = 1'b0;
        send(8'h11, 5, 1'b0);
        send(8'h22, 4, 1'b0);
        send(8'h44, 4, 1'b0);
        send(8'h33, 2, 1'b0);
        expect_out("R7 smgmt first", 1, 1, 8'h33);
        pulse_ack();
        expect_out("R3 nmask kept first vector", 1, 2, 8'h22);
        pulse_ack();
        expect_out("R7 start", 1, 3, 8'h11);
        pulse_ack();
        expect_out("R5 summary cleared", 0, 0, 0);
    endtask

    task automatic t_external();
        int_en = 1'b1;
        send(8'h90, 0, 1'b0);
        send(8'h20, 7, 1'b0);
        send(8'h21, 7, 1'b0);
        expect_out("R4 ext wins", 1, 4, 8'h20);
        int_en = 1'b0;
        @(negedge clk);
        chk("R5 ext masked", int'(take_irq), 0);
        int_en = 1'b1;
        pulse_ack();
        expect_out("R7 regular after ext", 1, 5, 8'h90);
        pulse_ack();
        pulse_eoi();
        expect_out("R8 done", 0, 0, 0);
    endtask

    task automatic t_reserved();
        send(8'h99, 3, 1'b0);
        send(8'hAA, 6, 1'b1);
        expect_out("R4 reserved", 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vector = '0; req_mode = '0; req_level = 1'b0;
        int_en = 1'b0; task_prio = '0; ack = 1'b0; eoi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regular_nesting();
        t_task_prio();
        t_trigger();
        t_special();
        t_external();
        t_reserved();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule